// File: doc/BRIEF.md
# Sign-Split Accumulate-and-Dump MAC Group

This block is the digital behavioural model of a wide group of low-precision multiply-accumulate lanes that share a single result converter. On every accepted beat, each of the eight lanes receives one 3-bit sign-magnitude activation slice and one 3-bit sign-magnitude weight slice. The lane multiplies the two 2-bit magnitudes. The sign of the product, which is the XOR of the two sign bits, steers the product into either the lane's positive accumulator or its negative accumulator. The two polarities are never mixed inside a lane.

A window is a programmed number of accepted beats, from 1 to 32. After the last beat of a window has been absorbed, a combine step adds up all positive accumulators and all negative accumulators across the group. It subtracts the negative total from the positive total and passes the difference to a quantizer. The quantizer clips the difference to a signed 10-bit range and reports whether it clipped. In the same cycle, every private accumulator is cleared or reloaded with the first product of the next window. This lets windows follow one another with no idle beat: conversion of one window overlaps accumulation of the next.

A `start` pulse samples the window length and begins a fresh window. Windows then repeat with that length until the next `start`. Beats that arrive with `in_valid` low do not advance the window.

Top module: `sgmac_group`

## Requirements
- R1: While reset is asserted, and after it is released until the first window completes, `res_valid`, `res_data` and `res_ovf` are all 0.
- R2: Lane i uses activation bits [3i+2:3i] and weight bits [3i+2:3i], where bit 3i+2 is the sign (1 = negative) and bits [3i+1:3i] are the magnitude. The unclipped window result is the sum, over all lanes and all accepted beats of the window, of (magnitude product) negated when the two sign bits differ.
- R3: `start` samples `cfg_len`: 0 is treated as 1, and values above 32 are treated as 32. Exactly one single-cycle `res_valid` pulse is produced for each window of that many accepted beats.
- R4: `res_valid` rises after the second rising edge following the edge that accepts the last beat of a window.
- R5: Without a new `start`, windows repeat back to back with the same length. Each result depends only on its own window's beats, with no residue from earlier windows.
- R6: `res_data` is the signed window result clipped to -512..511. `res_ovf` is 1 exactly when clipping occurred. Both hold their values between `res_valid` pulses.
- R7: A cycle with `in_valid` low and `start` low changes neither the window count nor any accumulator. It only delays the window's completion.
- R8: Beats before the first `start` after reset are ignored. A `start` in the middle of a window discards that window's partial sum. A beat presented in the same cycle as `start` is the first beat of the new window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a new window and sample `cfg_len` |
| cfg_len | input | 6 | Window length in accepted beats (clamped to 1..32) |
| in_valid | input | 1 | Operand slices on `act_sl`/`wgt_sl` are valid this cycle |
| act_sl | input | 24 | Eight 3-bit sign-magnitude activation slices |
| wgt_sl | input | 24 | Eight 3-bit sign-magnitude weight slices |
| res_valid | output | 1 | One-cycle pulse when a window result is presented |
| res_data | output | 10 | Clipped signed window result |
| res_ovf | output | 1 | Result was clipped |

## Verification
The checker watches four things on every cycle. First, each combine step is followed by exactly one result pulse, one cycle later. Second, the window count never reaches the programmed length. Third, an idle cycle leaves the count untouched. Fourth, the outputs hold between pulses, and a clipped result sits on a rail. Only the bench scenarios can show that the arithmetic is right. They compare each result value against an independent model across mixed signs, saturation in both directions, clamped lengths, gapped input, back-to-back windows, aborted windows and ignored pre-start beats. The bench also checks the exact cycle of every result pulse.

// File: rtl/sgmac_pkg.sv
package sgmac_pkg;
  localparam int unsigned DEF_LANES   = 8;
  localparam int unsigned DEF_MAG_W   = 2;
  localparam int unsigned DEF_WIN_MAX = 32;
  localparam int unsigned DEF_OUT_W   = 10;

  typedef enum logic {
    POL_POS = 1'b0,
    POL_NEG = 1'b1
  } polarity_e;
endpackage

// File: rtl/sgmac_winctl.sv
module sgmac_winctl #(
  parameter int unsigned WIN_MAX = 32,
  parameter int unsigned CNT_W   = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             in_valid,
  input  logic [CNT_W-1:0] cfg_len,
  output logic             accept,
  output logic             p_valid,
  output logic             p_first,
  output logic             dump,
  output logic [CNT_W-1:0] win_cnt,
  output logic [CNT_W-1:0] win_len
);
  localparam logic [CNT_W-1:0] LEN_MAX = CNT_W'(WIN_MAX);
  localparam logic [CNT_W-1:0] LEN_ONE = CNT_W'(1);

  logic             armed_q, armed_d;
  logic [CNT_W-1:0] len_q, len_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pv_q, pv_d;
  logic             pf_q, pf_d;
  logic             pl_q, pl_d;
  logic             dump_q, dump_d;
  logic [CNT_W-1:0] len_req, len_eff, cnt_eff;
  logic             beat_last;

  // next-state
  always_comb begin
    if (cfg_len == '0)          len_req = LEN_ONE;
    else if (cfg_len > LEN_MAX) len_req = LEN_MAX;
    else                        len_req = cfg_len;

    len_eff   = start ? len_req : len_q;
    cnt_eff   = start ? '0 : cnt_q;
    accept    = in_valid && (armed_q || start);
    beat_last = ((cnt_eff + LEN_ONE) == len_eff);

    armed_d = armed_q | start;
    len_d   = len_eff;
    if (accept) cnt_d = beat_last ? '0 : (cnt_eff + LEN_ONE);
    else        cnt_d = cnt_eff;

    pv_d   = accept;
    pf_d   = accept && (cnt_eff == '0);
    pl_d   = accept && beat_last;
    dump_d = pv_q && pl_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      len_q   <= LEN_ONE;
      cnt_q   <= '0;
      pv_q    <= 1'b0;
      pf_q    <= 1'b0;
      pl_q    <= 1'b0;
      dump_q  <= 1'b0;
    end else begin
      if (start) begin
        armed_q <= armed_d;
        len_q   <= len_d;
      end
      cnt_q  <= cnt_d;
      pv_q   <= pv_d;
      pf_q   <= pf_d;
      pl_q   <= pl_d;
      dump_q <= dump_d;
    end
  end

  assign p_valid = pv_q;
  assign p_first = pf_q;
  assign dump    = dump_q;
  assign win_cnt = cnt_q;
  assign win_len = len_q;
endmodule

// File: rtl/sgmac_lane.sv
module sgmac_lane
  import sgmac_pkg::*;
#(
  parameter int unsigned MAG_W  = 2,
  parameter int unsigned LACC_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              p_valid,
  input  logic              p_first,
  input  logic              dump,
  input  logic [MAG_W:0]    a_sl,
  input  logic [MAG_W:0]    w_sl,
  output logic [LACC_W-1:0] pos_acc,
  output logic [LACC_W-1:0] neg_acc
);
  localparam int unsigned PROD_W = 2 * MAG_W;

  logic [PROD_W-1:0] mag_q, mag_d;
  polarity_e         pol_q, pol_d;
  logic [LACC_W-1:0] pos_q, pos_d, neg_q, neg_d;
  logic [LACC_W-1:0] add_pos, add_neg;
  logic              restart, acc_en;

  // product stage next-state
  always_comb begin
    mag_d = PROD_W'(a_sl[MAG_W-1:0]) * PROD_W'(w_sl[MAG_W-1:0]);
    pol_d = polarity_e'(a_sl[MAG_W] ^ w_sl[MAG_W]);
  end

  // accumulator next-state
  always_comb begin
    restart = p_first || dump;
    acc_en  = p_valid || dump;
    add_pos = (p_valid && (pol_q == POL_POS)) ? LACC_W'(mag_q) : '0;
    add_neg = (p_valid && (pol_q == POL_NEG)) ? LACC_W'(mag_q) : '0;
    if (p_valid) begin
      pos_d = (restart ? '0 : pos_q) + add_pos;
      neg_d = (restart ? '0 : neg_q) + add_neg;
    end else begin
      pos_d = dump ? '0 : pos_q;
      neg_d = dump ? '0 : neg_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mag_q <= '0;
      pol_q <= POL_POS;
    end else if (accept) begin
      mag_q <= mag_d;
      pol_q <= pol_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
      neg_q <= '0;
    end else if (acc_en) begin
      pos_q <= pos_d;
      neg_q <= neg_d;
    end
  end

  assign pos_acc = pos_q;
  assign neg_acc = neg_q;
endmodule

// File: rtl/sgmac_combine.sv
module sgmac_combine #(
  parameter int unsigned LANES  = 8,
  parameter int unsigned LACC_W = 9,
  parameter int unsigned DIFF_W = 13
) (
  input  logic [LANES*LACC_W-1:0] pos_bus,
  input  logic [LANES*LACC_W-1:0] neg_bus,
  output logic signed [DIFF_W-1:0] diff
);
  localparam int unsigned TOT_W = DIFF_W - 1;

  logic [TOT_W-1:0] tot_p, tot_n;

  always_comb begin
    tot_p = '0;
    tot_n = '0;
    for (int i = 0; i < int'(LANES); i++) begin
      tot_p = tot_p + TOT_W'(pos_bus[i*LACC_W +: LACC_W]);
      tot_n = tot_n + TOT_W'(neg_bus[i*LACC_W +: LACC_W]);
    end
    diff = $signed({1'b0, tot_p}) - $signed({1'b0, tot_n});
  end
endmodule

// File: rtl/sgmac_quant.sv
module sgmac_quant #(
  parameter int unsigned DIFF_W = 13,
  parameter int unsigned OUT_W  = 10
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     dump,
  input  logic signed [DIFF_W-1:0] diff,
  output logic                     res_valid,
  output logic [OUT_W-1:0]         res_data,
  output logic                     res_ovf
);
  localparam logic signed [DIFF_W-1:0] HI = DIFF_W'((2 ** (OUT_W - 1)) - 1);
  localparam logic signed [DIFF_W-1:0] LO = ~HI;

  logic             vld_q;
  logic [OUT_W-1:0] dat_q, dat_d;
  logic             ovf_q, ovf_d;

  always_comb begin
    if (diff > HI) begin
      dat_d = HI[OUT_W-1:0];
      ovf_d = 1'b1;
    end else if (diff < LO) begin
      dat_d = LO[OUT_W-1:0];
      ovf_d = 1'b1;
    end else begin
      dat_d = diff[OUT_W-1:0];
      ovf_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dat_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      vld_q <= dump;
      if (dump) begin
        dat_q <= dat_d;
        ovf_q <= ovf_d;
      end
    end
  end

  assign res_valid = vld_q;
  assign res_data  = dat_q;
  assign res_ovf   = ovf_q;
endmodule

// File: rtl/sgmac_group.sv
module sgmac_group
  import sgmac_pkg::*;
#(
  parameter int unsigned LANES   = DEF_LANES,
  parameter int unsigned MAG_W   = DEF_MAG_W,
  parameter int unsigned WIN_MAX = DEF_WIN_MAX,
  parameter int unsigned OUT_W   = DEF_OUT_W
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             start,
  input  logic [$clog2(WIN_MAX+1)-1:0]     cfg_len,
  input  logic                             in_valid,
  input  logic [LANES*(MAG_W+1)-1:0]       act_sl,
  input  logic [LANES*(MAG_W+1)-1:0]       wgt_sl,
  output logic                             res_valid,
  output logic [OUT_W-1:0]                 res_data,
  output logic                             res_ovf
);
  localparam int unsigned SL_W   = MAG_W + 1;
  localparam int unsigned PROD_W = 2 * MAG_W;
  localparam int unsigned CNT_W  = $clog2(WIN_MAX + 1);
  localparam int unsigned LACC_W = PROD_W + $clog2(WIN_MAX);
  localparam int unsigned TOT_W  = LACC_W + $clog2(LANES);
  localparam int unsigned DIFF_W = TOT_W + 1;

  logic                     accept, p_valid, p_first, dump;
  logic [CNT_W-1:0]         win_cnt, win_len;
  logic [LANES*LACC_W-1:0]  pos_bus, neg_bus;
  logic signed [DIFF_W-1:0] diff;

  sgmac_winctl #(
    .WIN_MAX (WIN_MAX),
    .CNT_W   (CNT_W)
  ) u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .in_valid (in_valid),
    .cfg_len  (cfg_len),
    .accept   (accept),
    .p_valid  (p_valid),
    .p_first  (p_first),
    .dump     (dump),
    .win_cnt  (win_cnt),
    .win_len  (win_len)
  );

  for (genvar g = 0; g < int'(LANES); g++) begin : g_lane
    sgmac_lane #(
      .MAG_W  (MAG_W),
      .LACC_W (LACC_W)
    ) u_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .accept  (accept),
      .p_valid (p_valid),
      .p_first (p_first),
      .dump    (dump),
      .a_sl    (act_sl[g*SL_W +: SL_W]),
      .w_sl    (wgt_sl[g*SL_W +: SL_W]),
      .pos_acc (pos_bus[g*LACC_W +: LACC_W]),
      .neg_acc (neg_bus[g*LACC_W +: LACC_W])
    );
  end

  sgmac_combine #(
    .LANES  (LANES),
    .LACC_W (LACC_W),
    .DIFF_W (DIFF_W)
  ) u_comb (
    .pos_bus (pos_bus),
    .neg_bus (neg_bus),
    .diff    (diff)
  );

  sgmac_quant #(
    .DIFF_W (DIFF_W),
    .OUT_W  (OUT_W)
  ) u_quant (
    .clk       (clk),
    .rst_n     (rst_n),
    .dump      (dump),
    .diff      (diff),
    .res_valid (res_valid),
    .res_data  (res_data),
    .res_ovf   (res_ovf)
  );
endmodule

// File: rtl/sgmac_chk.sv
module sgmac_chk #(
  parameter int unsigned CNT_W = 6,
  parameter int unsigned OUT_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             in_valid,
  input logic             dump,
  input logic [CNT_W-1:0] win_cnt,
  input logic [CNT_W-1:0] win_len,
  input logic             res_valid,
  input logic [OUT_W-1:0] res_data,
  input logic             res_ovf
);
  localparam logic [OUT_W-1:0] RAIL_HI = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] RAIL_LO = {1'b1, {(OUT_W-1){1'b0}}};

  AST_DUMP_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    dump |=> res_valid); // R4

  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !dump |=> !res_valid); // R3

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    win_cnt < win_len); // R3

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !start) |=> $stable(win_cnt)); // R7

  AST_CLIP_RAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ovf) |-> (res_data == RAIL_HI || res_data == RAIL_LO)); // R6

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> ($stable(res_data) && $stable(res_ovf))); // R6
endmodule

bind sgmac_group sgmac_chk #(
  .CNT_W (CNT_W),
  .OUT_W (OUT_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .in_valid  (in_valid),
  .dump      (dump),
  .win_cnt   (win_cnt),
  .win_len   (win_len),
  .res_valid (res_valid),
  .res_data  (res_data),
  .res_ovf   (res_ovf)
);

// File: tb/tb_sgmac_group.sv
`timescale 1ns/1ps
module tb_sgmac_group;
  localparam int LANES = 8;
  localparam int SL    = 3;
  localparam int CW    = 6;
  localparam int OW    = 10;
  localparam int NV    = 10;
  localparam int QD    = 64;

  // table entry: [15:10] raw length, [9:8] data mode, [7:1] seed, [0] gap
  localparam logic [15:0] VEC [NV] = '{
    {6'd32, 2'd0, 7'd1, 1'b0},
    {6'd1,  2'd0, 7'd2, 1'b0},
    {6'd5,  2'd0, 7'd3, 1'b1},
    {6'd32, 2'd1, 7'd0, 1'b0},
    {6'd32, 2'd2, 7'd0, 1'b0},
    {6'd0,  2'd1, 7'd0, 1'b0},
    {6'd63, 2'd1, 7'd0, 1'b0},
    {6'd7,  2'd1, 7'd0, 1'b0},
    {6'd7,  2'd2, 7'd0, 1'b0},
    {6'd17, 2'd0, 7'd9, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic in_valid = 1'b0;
  logic [CW-1:0] cfg_len = '0;
  logic [LANES*SL-1:0] act_sl = '0;
  logic [LANES*SL-1:0] wgt_sl = '0;
  logic res_valid;
  logic [OW-1:0] res_data;
  logic res_ovf;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  int    got_d [QD];
  bit    got_o [QD];
  int    got_c [QD];
  int    n_got = 0;
  int    exp_d [QD];
  bit    exp_o [QD];
  int    exp_c [QD];
  string exp_t [QD];
  int    n_exp = 0;

  sgmac_group dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .cfg_len   (cfg_len),
    .in_valid  (in_valid),
    .act_sl    (act_sl),
    .wgt_sl    (wgt_sl),
    .res_valid (res_valid),
    .res_data  (res_data),
    .res_ovf   (res_ovf)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n && res_valid && n_got < QD) begin
      got_d[n_got] = $signed(res_data);
      got_o[n_got] = res_ovf;
      got_c[n_got] = cyc;
      n_got++;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] gen(input int mode, input int seed, input int beat,
                                     input int lane, input bit isw);
    int v;
    case (mode)
      1: return 3'b011;
      2: return isw ? 3'b011 : 3'b111;
      default: begin
        v = seed * 37 + beat * 11 + lane * 5 + (isw ? (beat * lane + 3) : (lane * lane));
        return v[2:0];
      end
    endcase
  endfunction

  function automatic int sprod(input logic [2:0] a, input logic [2:0] w);
    int m;
    m = int'(a[1:0]) * int'(w[1:0]);
    return (a[2] ^ w[2]) ? -m : m;
  endfunction

  function automatic int eff_len(input int raw);
    if (raw == 0) return 1;
    if (raw > 32) return 32;
    return raw;
  endfunction

  task automatic drive_beat(input int mode, input int seed, input int beat, input bit st,
                            input int len, output int psum, output int dcyc);
    logic [2:0] a, w;
    psum = 0;
    for (int l = 0; l < LANES; l++) begin
      a = gen(mode, seed, beat, l, 1'b0);
      w = gen(mode, seed, beat, l, 1'b1);
      act_sl[l*SL +: SL] = a;
      wgt_sl[l*SL +: SL] = w;
      psum += sprod(a, w);
    end
    in_valid = 1'b1;
    start    = st;
    cfg_len  = CW'(len);
    dcyc     = cyc;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    start    = 1'b0;
    act_sl   = {LANES{3'b011}};
    wgt_sl   = {LANES{3'b011}};
    repeat (n) @(negedge clk);
  endtask

  task automatic push_exp(input int sum, input int dcyc, input string tag);
    if (sum > 511) begin
      exp_d[n_exp] = 511;  exp_o[n_exp] = 1'b1;
    end else if (sum < -512) begin
      exp_d[n_exp] = -512; exp_o[n_exp] = 1'b1;
    end else begin
      exp_d[n_exp] = sum;  exp_o[n_exp] = 1'b0;
    end
    exp_c[n_exp] = dcyc + 3;   // accept edge, accumulate edge, result edge
    exp_t[n_exp] = tag;
    n_exp++;
  endtask

  task automatic run_window(input int raw, input int mode, input int seed, input bit gap,
                            input bit use_start, input string tag);
    int n, sum, p, dc;
    n = eff_len(raw);
    sum = 0;
    dc = 0;
    for (int b = 0; b < n; b++) begin
      drive_beat(mode, seed, b, use_start && (b == 0), raw, p, dc);
      sum += p;
      if (gap && (b % 2 == 0) && (b != n - 1)) idle(2);
    end
    push_exp(sum, dc, tag);
  endtask

  function automatic string vec_tag(input int k);
    case (k)
      2:       return "R7";
      3, 4, 7, 8: return "R6";
      1, 5, 6: return "R3";
      default: return "R2";
    endcase
  endfunction

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(4 * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int p, dc;
    logic [OW-1:0] held_d;
    logic held_o;

    // R1: outputs quiet during and right after reset
    repeat (3) @(negedge clk);
    check("R1 valid in reset", int'(res_valid), 0);
    check("R1 data in reset", int'(res_data), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", int'({res_valid, res_ovf, res_data}), 0);

    // R8: beats before any start are ignored
    for (int b = 0; b < 4; b++) drive_beat(1, 0, b, 1'b0, 1, p, dc);
    idle(6);
    check("R8 no result before start", n_got, 0);

    // table walk
    for (int k = 0; k < NV; k++) begin
      logic [15:0] e;
      e = VEC[k];
      run_window(int'(e[15:10]), int'(e[9:8]), int'(e[7:1]), e[0], 1'b1, vec_tag(k));
    end
    idle(4);

    // R5: automatic repeat with cleared accumulators
    run_window(3, 1, 0, 1'b0, 1'b1, "R5");
    run_window(3, 2, 0, 1'b0, 1'b0, "R5");
    idle(4);

    // R8: abort a partial window with a new start
    drive_beat(1, 0, 0, 1'b1, 4, p, dc);
    drive_beat(1, 0, 1, 1'b0, 4, p, dc);
    run_window(2, 2, 0, 1'b0, 1'b1, "R8");
    idle(5);

    // R6: outputs hold between pulses
    held_d = res_data;
    held_o = res_ovf;
    idle(6);
    check("R6 data held", int'(res_data), int'(held_d));
    check("R6 ovf held", int'(res_ovf), int'(held_o));

    // R3: one pulse per window
    check("R3 result count", n_got, n_exp);
    for (int i = 0; i < n_exp && i < n_got; i++) begin
      check({exp_t[i], " value"}, got_d[i], exp_d[i]);
      check({exp_t[i], " clip flag"}, int'(got_o[i]), int'(exp_o[i]));
      check({exp_t[i], " R4 cycle"}, got_c[i], exp_c[i]);
    end
    finish_run();
  end
endmodule